// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block splits every nominal CAN bit into programmable time quanta, all derived from the system clock. It emits a one-cycle strobe at the sample point together with the bit value taken there, and a one-cycle strobe where a new bit time begins, which the transmitter uses to drive its next bit. A bit time is one synchronization quantum, then a propagation segment, then phase segment 1, then phase segment 2. The sample point sits at the end of phase segment 1.

The unit watches the receive line for recessive-to-dominant (1 to 0) edges. When the protocol sequencer says a start of frame is expected, such an edge hard-synchronizes the unit: the bit time and the quantum divider both restart. At any other time an edge re-synchronizes the unit. A late edge stretches phase segment 1 and an early edge trims phase segment 2, each by no more than the jump width. No re-synchronization takes place while the node itself drives a dominant bit. Only one synchronization is taken per bit time. An optional mode returns the majority of three samples instead of a single sample.

The frame-level logic is outside this block. It drives `sof_expect` and `tx_dom` and consumes the two strobes.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(tq_div+1) clock cycles, and with no synchronization a bit lasts 1+prop_tq+ph1_tq+ph2_tq quanta, so consecutive sample_stb pulses are that many quanta apart.
- R2: A 1-to-0 edge on rx_in while sof_expect is 1 is a hard synchronization. If the clock edge that first sees rx_in low is cycle 0, sample_stb is high in the cycle that follows clock edge (prop_tq+ph1_tq+1)*T, where T is the quantum length in clocks.
- R3: sample_stb is a single-cycle pulse. rx_bit changes only together with it. With triple_en at 0, rx_bit takes the rx_in value present at the last clock edge of phase segment 1.
- R4: tx_stb is a single-cycle pulse that marks the start of each bit time. It never coincides with sample_stb. After a hard synchronization it first rises one full bit time after cycle 0.
- R5: An edge seen while the quantum index k is in 1..prop_tq+ph1_tq, where index 0 is the synchronization quantum, is late. It delays that bit's sample point and its end by min(k, sjw_tq) quanta.
- R6: An edge seen after the sample point is early. If fewer than sjw_tq+1 quanta of the bit remain, counting the current one, the bit time restarts at once and tx_stb follows that edge. Otherwise phase segment 2 is shortened by sjw_tq quanta.
- R7: While tx_dom is 1, an edge outside the start-of-frame state leaves the bit timing unchanged.
- R8: After any synchronization, further edges are ignored until the next sample point.
- R9: With triple_en at 1, rx_bit is the majority of rx_in taken at the last clock edges of the two quanta before the sample quantum and of the sample quantum itself.
- R10: While rst_n is low, sample_stb and tx_stb are 0 and rx_bit is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Receive line, already synchronous to clk (0 = dominant) |
| tq_div | input | BRP_W | Quantum divider; quantum = 2*(tq_div+1) clocks |
| prop_tq | input | SEG_W | Propagation segment length in quanta (at least 1) |
| ph1_tq | input | SEG_W | Phase segment 1 length in quanta (at least 1) |
| ph2_tq | input | SEG_W | Phase segment 2 length in quanta (at least 1) |
| sjw_tq | input | SJW_W | Jump width in quanta |
| triple_en | input | 1 | Selects the three-sample majority vote |
| tx_dom | input | 1 | Node is currently driving a dominant bit |
| sof_expect | input | 1 | Sequencer expects a start of frame (bus idle) |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| tx_stb | output | 1 | One-cycle pulse at the start of a bit time |
| rx_bit | output | 1 | Bit value taken at the latest sample point |

## Verification
A wrong quantum index, lengthening, or shortening register shows up as a sample_stb or tx_stb pulse that arrives a whole number of quanta early or late, within the bit time in which the fault arises. The bench therefore pins every strobe to an absolute clock cycle computed from the edge cycle. A wrong synchronization-permission flag shows up the same way in the next bit: an edge that should have been ignored moves the sample point, or one that should have acted does not. Faults in the sample history show up only as a wrong rx_bit at a sample point in triple mode. The bench drives rx_in patterns in which the majority vote and a single sample disagree.

// File: rtl/can_btm_pkg.sv
package can_btm_pkg;

   typedef enum logic [1:0] {
      SYNC_IDLE,
      SYNC_HARD,
      SYNC_LATE,
      SYNC_EARLY
   } sync_kind_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/btm_quantum_div.sv
module btm_quantum_div #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] div,
   input  logic             restart,
   output logic             tq_tick
);
   localparam int CW = BRP_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          wrap;

   always_comb begin
      last    = {div, 1'b1};
      wrap    = (cnt >= last);
      tq_tick = wrap & ~restart;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (wrap)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/btm_seg_ctrl.sv
module btm_seg_ctrl
   import can_btm_pkg::*;
#(
   parameter int SEG_W = 4,
   parameter int SJW_W = 2,
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tq_tick,
   input  logic             edge_fall,
   input  logic             sof_expect,
   input  logic             tx_dom,
   input  logic [SEG_W-1:0] prop_len,
   input  logic [SEG_W-1:0] ph1_len,
   input  logic [SEG_W-1:0] ph2_len,
   input  logic [SJW_W-1:0] sjw,
   output logic             restart,
   output logic             sample_hit,
   output logic             bit_start
);
   logic [POS_W-1:0] pos, ext, shrink;
   logic [POS_W-1:0] sp_eff, end_pos, sjw_w, late_amt;
   logic             sync_ok;
   logic             early_restart;
   sync_kind_e       kind;

   always_comb begin
      sjw_w    = POS_W'(sjw);
      sp_eff   = POS_W'(prop_len) + POS_W'(ph1_len) + ext;
      end_pos  = sp_eff + POS_W'(ph2_len) - shrink;
      late_amt = (pos < sjw_w) ? pos : sjw_w;
      kind     = SYNC_IDLE;
      if (edge_fall && sync_ok) begin
         if (sof_expect)
            kind = SYNC_HARD;
         else if (!tx_dom && (pos != '0))
            kind = (pos <= sp_eff) ? SYNC_LATE : SYNC_EARLY;
      end
      early_restart = (kind == SYNC_EARLY) && ((pos + sjw_w) > end_pos);
      restart       = (kind == SYNC_HARD) || early_restart;
      sample_hit    = tq_tick && (pos == sp_eff) && !restart;
      bit_start     = early_restart || (tq_tick && (pos >= end_pos) && !restart);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         ext     <= '0;
         shrink  <= '0;
         sync_ok <= 1'b1;
      end else if (restart) begin
         pos     <= '0;
         ext     <= '0;
         shrink  <= '0;
         sync_ok <= 1'b0;
      end else begin
         if (kind == SYNC_LATE) begin
            ext     <= late_amt;
            sync_ok <= 1'b0;
         end
         if (kind == SYNC_EARLY) begin
            shrink  <= sjw_w;
            sync_ok <= 1'b0;
         end
         if (tq_tick) begin
            if (pos >= end_pos) begin
               pos    <= '0;
               ext    <= '0;
               shrink <= '0;
            end else begin
               pos <= pos + 1'b1;
            end
         end
         if (sample_hit) sync_ok <= 1'b1;
      end
   end
endmodule

// File: rtl/btm_sampler.sv
module btm_sampler
   import can_btm_pkg::*;
#(
   parameter bit HAS_TRIPLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tq_tick,
   input  logic sample_hit,
   input  logic rx,
   input  logic triple_en,
   output logic rx_bit,
   output logic sample_stb
);
   logic next_bit;

   generate
      if (HAS_TRIPLE) begin : g_vote
         logic [1:0] hist;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hist <= 2'b11;
            else if (tq_tick) hist <= {hist[0], rx};
         end
         assign next_bit = triple_en ? vote3(hist[1], hist[0], rx) : rx;
      end else begin : g_single
         assign next_bit = rx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_bit     <= 1'b1;
         sample_stb <= 1'b0;
      end else begin
         sample_stb <= sample_hit;
         if (sample_hit) rx_bit <= next_bit;
      end
   end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int BRP_W      = 6,
   parameter int SEG_W      = 4,
   parameter int SJW_W      = 2,
   parameter bit HAS_TRIPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic [BRP_W-1:0] tq_div,
   input  logic [SEG_W-1:0] prop_tq,
   input  logic [SEG_W-1:0] ph1_tq,
   input  logic [SEG_W-1:0] ph2_tq,
   input  logic [SJW_W-1:0] sjw_tq,
   input  logic             triple_en,
   input  logic             tx_dom,
   input  logic             sof_expect,
   output logic             sample_stb,
   output logic             tx_stb,
   output logic             rx_bit
);
   localparam int SEG_MAX = (1 << SEG_W) - 1;
   localparam int SJW_MAX = (1 << SJW_W) - 1;
   localparam int POS_W   = $clog2(3 * SEG_MAX + SJW_MAX + 2) + 1;

   generate
      if (BRP_W < 1 || SEG_W < 2 || SJW_W < 1 || SJW_W > SEG_W) begin : g_bad_cfg
         $error("can_bit_timer: unsupported width parameters");
      end
   endgenerate

   logic rx_q, edge_fall;
   logic tq_tick, restart, sample_hit, bit_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= 1'b1;
         tx_stb <= 1'b0;
      end else begin
         rx_q   <= rx_in;
         tx_stb <= bit_start;
      end
   end

   assign edge_fall = rx_q & ~rx_in;

   btm_quantum_div #(.BRP_W(BRP_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div(tq_div), .restart(restart), .tq_tick(tq_tick)
   );

   btm_seg_ctrl #(.SEG_W(SEG_W), .SJW_W(SJW_W), .POS_W(POS_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .edge_fall(edge_fall),
      .sof_expect(sof_expect), .tx_dom(tx_dom), .prop_len(prop_tq),
      .ph1_len(ph1_tq), .ph2_len(ph2_tq), .sjw(sjw_tq),
      .restart(restart), .sample_hit(sample_hit), .bit_start(bit_start)
   );

   btm_sampler #(.HAS_TRIPLE(HAS_TRIPLE)) u_smp (
      .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .sample_hit(sample_hit),
      .rx(rx_in), .triple_en(triple_en), .rx_bit(rx_bit), .sample_stb(sample_stb)
   );
endmodule

// File: rtl/can_bit_timer_checks.sv
module can_bit_timer_checks (
   input logic clk,
   input logic rst_n,
   input logic sample_stb,
   input logic tx_stb,
   input logic rx_bit
);
   // R3: the sample strobe lasts one cycle
   p_sample_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   // R3: the sampled bit moves only with the sample strobe
   p_rxbit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |-> $stable(rx_bit));

   // R4: the bit-start strobe lasts one cycle
   p_tx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb |=> !tx_stb);

   // R4: the two strobes never coincide
   p_strobe_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !tx_stb);
endmodule

bind can_bit_timer can_bit_timer_checks u_checks (
   .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic [5:0] tq_div = '0;
   logic [3:0] prop_tq = 4'd2, ph1_tq = 4'd3, ph2_tq = 4'd3;
   logic [1:0] sjw_tq = 2'd1;
   logic       triple_en = 1'b0, tx_dom = 1'b0, sof_expect = 1'b1;
   logic       sample_stb, tx_stb, rx_bit;
   int         cyc = 0, n_chk = 0, n_err = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   can_bit_timer u_can_bit_timer (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tq_div(tq_div), .prop_tq(prop_tq),
      .ph1_tq(ph1_tq), .ph2_tq(ph2_tq), .sjw_tq(sjw_tq), .triple_en(triple_en),
      .tx_dom(tx_dom), .sof_expect(sof_expect), .sample_stb(sample_stb),
      .tx_stb(tx_stb), .rx_bit(rx_bit)
   );

   // {div, prop, ph1, ph2, clocks edge->first sample, clocks per bit}
   localparam logic [35:0] VEC [4] = '{
      {8'd0, 4'd1, 4'd1, 4'd1, 8'd6,  8'd8},
      {8'd1, 4'd2, 4'd3, 4'd3, 8'd24, 8'd36},
      {8'd2, 4'd4, 4'd2, 4'd5, 8'd42, 8'd72},
      {8'd0, 4'd8, 4'd8, 4'd8, 8'd34, 8'd50}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic wait_to(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic see_sample(input int t, input bit v, input string req);
      wait_to(t);
      check(sample_stb === 1'b1, req, int'(sample_stb), 1);
      check(rx_bit === v, req, int'(rx_bit), int'(v));
   endtask

   task automatic see_tx(input int t, input string req);
      wait_to(t);
      check(tx_stb === 1'b1, req, int'(tx_stb), 1);
   endtask

   task automatic hs_start(input int dv, input int pr, input int p1, input int p2,
                           input int sj, input bit tri3, output int e);
      @(negedge clk);
      tq_div = 6'(dv); prop_tq = 4'(pr); ph1_tq = 4'(p1); ph2_tq = 4'(p2);
      sjw_tq = 2'(sj); triple_en = tri3; tx_dom = 1'b0; sof_expect = 1'b1; rx_in = 1'b1;
      repeat (4) @(negedge clk);
      rx_in = 1'b0;
      e = cyc + 1;
   endtask

   // default directed setup: T=2, sample index 5, 9 quanta per bit
   task automatic std_start(input int sj, output int e);
      hs_start(0, 2, 3, 3, sj, 1'b0, e);
      see_sample(e + 12, 1'b0, "R2");
      rx_in = 1'b1;
      sof_expect = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int e;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(sample_stb === 1'b0, "R10", int'(sample_stb), 0);
      check(tx_stb === 1'b0, "R10", int'(tx_stb), 0);
      check(rx_bit === 1'b1, "R10", int'(rx_bit), 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R2 R4: table walk over prescaler and segment settings
      for (int i = 0; i < 4; i++) begin
         int fs, per;
         fs  = int'(VEC[i][15:8]);
         per = int'(VEC[i][7:0]);
         hs_start(int'(VEC[i][35:28]), int'(VEC[i][27:24]), int'(VEC[i][23:20]),
                  int'(VEC[i][19:16]), 1, 1'b0, e);
         see_sample(e + fs, 1'b0, "R2");
         rx_in = 1'b1;
         sof_expect = 1'b0;
         see_tx(e + per, "R4");
         see_sample(e + per + fs, 1'b1, "R1");
      end

      // R5: late edge at index 1 stretches by 1 quantum
      std_start(2, e);
      wait_to(e + 20); rx_in = 1'b0;
      wait_to(e + 30);
      check(sample_stb === 1'b0, "R5", int'(sample_stb), 0);
      see_sample(e + 32, 1'b0, "R5");
      see_tx(e + 38, "R5");

      // R5: late edge at index 3 is capped at the jump width 2
      std_start(2, e);
      wait_to(e + 24); rx_in = 1'b0;
      see_sample(e + 34, 1'b0, "R5");

      // R7: own dominant bit blocks resync
      std_start(2, e);
      wait_to(e + 20); rx_in = 1'b0; tx_dom = 1'b1;
      see_sample(e + 30, 1'b0, "R7");
      tx_dom = 1'b0;

      // R8: second edge in the same bit is ignored
      std_start(2, e);
      wait_to(e + 20); rx_in = 1'b0;
      wait_to(e + 22); rx_in = 1'b1;
      wait_to(e + 24); rx_in = 1'b0;
      see_sample(e + 32, 1'b0, "R8");

      // R6: early edge, shortening by sjw=1
      std_start(1, e);
      see_sample(e + 30, 1'b1, "R3");
      rx_in = 1'b0;
      see_tx(e + 34, "R6");
      see_sample(e + 46, 1'b0, "R6");

      // R6: early edge within jump width restarts the bit
      std_start(2, e);
      wait_to(e + 32); rx_in = 1'b0;
      see_tx(e + 33, "R6");
      see_sample(e + 45, 1'b0, "R6");

      // R9: majority of 0,0,1 is 0
      hs_start(0, 2, 3, 3, 1, 1'b1, e);
      sof_expect = 1'b0;
      wait_to(e + 11); rx_in = 1'b1;
      see_sample(e + 12, 1'b0, "R9");

      // R3: single sample with the same pattern gives 1
      hs_start(0, 2, 3, 3, 1, 1'b0, e);
      sof_expect = 1'b0;
      wait_to(e + 11); rx_in = 1'b1;
      see_sample(e + 12, 1'b1, "R3");

      // R9: majority of 0,1,1 is 1
      hs_start(0, 2, 3, 3, 1, 1'b1, e);
      sof_expect = 1'b0;
      wait_to(e + 9); rx_in = 1'b1;
      see_sample(e + 12, 1'b1, "R9");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule